// File: doc/BRIEF.md
# SMBus Slave Block-Read Engine

This block is the transaction layer of an SMBus slave. It sits above a byte-level I2C slave front end. The front end reports START or repeated START, STOP, a matched slave address with its R/W bit, each received byte, and the master's ACK or NACK on each byte the slave transmits. The engine decodes a pointer-setup write: the block-read command F1h, a byte count of 02h, a start register address and a read length from 01h to 20h. The new pointer and length take effect only when a STOP closes that write.

A later block read is a write that carries only F1h, then a repeated START, then the slave address with the read bit set. The engine first returns the stored length N. It then streams register bytes from a 256-entry register file through a synchronous read port, and keeps doing so for as long as the master acknowledges. A NACK releases the bus. The base pointer is nine bits wide and always points just past the last data byte sent, so a repeated read resumes where the previous one stopped. The pointer never wraps. Once it has passed FFh, every byte read is 00h.

The fixed-address block commands F2h–FDh, and every other code, are refused.

Top module: `smb_blkrd_ctrl`

## Requirements
- R1: After reset the base pointer is 000h and the stored length is 01h, so the first read returns 01h followed by register 00h onward.
- R2: A write of F1h, 02h, address A, length L (01h ≤ L ≤ 20h) has every byte acknowledged (rx_ack high while ev_rx is high), and at the closing STOP the base becomes A and the length L.
- R3: A byte count other than 02h, or a length outside 01h–20h, is not acknowledged, and the stored pointer and length stay unchanged.
- R4: Any command code other than F1h, including F2h through FDh, is not acknowledged, and no later byte of that transaction is acknowledged.
- R5: A STOP before the length byte has been accepted discards the partial setup.
- R6: In a read armed by F1h and a repeated START, the first byte is the stored length N. The data bytes that follow come from rf_data for rf_addr equal to the base, which advances by one for each data byte sent. The length byte does not advance it.
- R7: Bytes beyond N keep being supplied for as long as the master acknowledges.
- R8: A master NACK (mack_ack low) drops tx_active on the next cycle, and further tx_req pulses produce no tx_valid.
- R9: A repeated read resumes at the address just past the last data byte sent, ACKed or NACKed, and returns the same N.
- R10: The base never wraps from FFh. Reads at 100h return 00h without asserting rf_rd.
- R11: A read address phase that is not preceded by an F1h write and a repeated START leaves tx_active low.
- R12: tx_valid rises exactly one cycle after a tx_req accepted while tx_active is high, carrying the byte in tx_byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | START or repeated START seen (pulse) |
| ev_stop | input | 1 | STOP seen (pulse) |
| ev_addr | input | 1 | Own slave address matched (pulse) |
| addr_rw | input | 1 | R/W bit with ev_addr, 1 = read |
| ev_rx | input | 1 | Byte received from master (pulse) |
| rx_byte | input | 8 | Received byte, valid with ev_rx |
| rx_ack | output | 1 | Combinational ACK decision for the byte on ev_rx |
| tx_req | input | 1 | Front end asks for the next byte to send (pulse) |
| tx_valid | output | 1 | Byte to send is ready, one cycle after tx_req |
| tx_byte | output | 8 | Byte to send, valid with tx_valid |
| ev_mack | input | 1 | Master ACK/NACK on the last sent byte (pulse) |
| mack_ack | input | 1 | 1 = master ACK, 0 = NACK |
| tx_active | output | 1 | Engine is streaming a read |
| rf_rd | output | 1 | Register file read strobe |
| rf_addr | output | 8 | Register file read address |
| rf_data | input | 8 | Register file data, one cycle after rf_rd |

## Verification
The bench aims first at the top of the register space. It sets up reads that start near FDh and run past FFh. A design that wraps the pointer would return register 00h there instead of zeros, and the same mistake would show again on the next read, which must resume at 100h. It also tests the byte that ends each read. A design that does not advance the pointer on the NACKed byte would repeat that byte on the following read. A design that advances it on the length byte would skip a byte. Malformed setups are driven too: a wrong count, a length of 00h or 21h, a fixed-block command, and a STOP in the middle of a setup. A design that stores partial values would then return the wrong length and start address on the next read.

// File: rtl/smb_blkrd_ctrl.sv
module smb_blkrd_ctrl #(
  parameter logic [7:0] CMD_BLKRD = 8'hF1,
  parameter logic [7:0] SETUP_CNT = 8'h02,
  parameter logic [7:0] MAX_LEN   = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_addr,
  input  logic       addr_rw,
  input  logic       ev_rx,
  input  logic [7:0] rx_byte,
  output logic       rx_ack,
  input  logic       tx_req,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  input  logic       ev_mack,
  input  logic       mack_ack,
  output logic       tx_active,
  output logic       rf_rd,
  output logic [7:0] rf_addr,
  input  logic [7:0] rf_data
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_CNT, ST_ADR, ST_LEN, ST_DONE, ST_ARM, ST_RD, ST_REL, ST_SKIP
  } st_t;

  st_t        state;
  logic [8:0] base;
  logic [7:0] len, tmp_adr, tmp_len;
  logic       first, sel_len, sel_zero, rx_ok;

  wire armed  = (state == ST_ARM);
  wire in_cmd = (state == ST_CMD);

  always_comb begin
    case (state)
      ST_CMD:  rx_ok = (rx_byte == CMD_BLKRD);
      ST_CNT:  rx_ok = (rx_byte == SETUP_CNT);
      ST_ADR:  rx_ok = 1'b1;
      ST_LEN:  rx_ok = (rx_byte != 8'h00) && (rx_byte <= MAX_LEN);
      default: rx_ok = 1'b0;
    endcase
  end

  assign rx_ack    = ev_rx & rx_ok;
  assign tx_active = (state == ST_RD);
  assign rf_addr   = base[7:0];
  assign rf_rd     = tx_req & tx_active & ~first & ~base[8];
  assign tx_byte   = !tx_valid ? 8'h00 : sel_len ? len : sel_zero ? 8'h00 : rf_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      base     <= 9'h000;
      len      <= 8'h01;
      tmp_adr  <= 8'h00;
      tmp_len  <= 8'h01;
      first    <= 1'b0;
      sel_len  <= 1'b0;
      sel_zero <= 1'b0;
      tx_valid <= 1'b0;
    end else begin
      tx_valid <= tx_req & tx_active;
      if (tx_req && tx_active) begin
        sel_len  <= first;
        sel_zero <= base[8];
      end
      if (ev_stop) begin
        if (state == ST_DONE) begin
          base <= {1'b0, tmp_adr};
          len  <= tmp_len;
        end
        state <= ST_IDLE;
      end else if (ev_start) begin
        state <= (state == ST_CNT) ? ST_ARM : ST_IDLE;
      end else if (ev_addr) begin
        if (!addr_rw) state <= ST_CMD;
        else if (armed) begin
          state <= ST_RD;
          first <= 1'b1;
        end else state <= ST_SKIP;
      end else if (ev_rx) begin
        if (state == ST_DONE) state <= ST_DONE;
        else if (!rx_ok) state <= ST_SKIP;
        else begin
          case (state)
            ST_CMD: state <= ST_CNT;
            ST_CNT: state <= ST_ADR;
            ST_ADR: begin tmp_adr <= rx_byte; state <= ST_LEN; end
            ST_LEN: begin tmp_len <= rx_byte; state <= ST_DONE; end
            default: state <= ST_SKIP;
          endcase
        end
      end else if (ev_mack && tx_active) begin
        if (first) first <= 1'b0;
        else if (!base[8]) base <= base + 9'd1;
        if (!mack_ack) state <= ST_REL;
      end
    end
  end
endmodule

// File: rtl/smb_blkrd_chk.sv
module smb_blkrd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_stop,
  input logic       ev_addr,
  input logic       addr_rw,
  input logic       ev_rx,
  input logic [7:0] rx_byte,
  input logic       rx_ack,
  input logic       tx_req,
  input logic       tx_valid,
  input logic       ev_mack,
  input logic       mack_ack,
  input logic       tx_active,
  input logic       rf_rd,
  input logic [8:0] base,
  input logic       armed,
  input logic       in_cmd
);
  // R12
  tx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && tx_active |=> tx_valid);
  // R12
  tx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(tx_req));
  // R8
  nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mack && !mack_ack && tx_active |=> !tx_active);
  // R10
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base[8] && !ev_stop |=> base[8]);
  // R4
  fixed_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx && in_cmd && (rx_byte >= 8'hF2) && (rx_byte <= 8'hFD) |-> !rx_ack);
  // R11
  unarmed_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr && addr_rw && !armed |=> !tx_active);
  // R6
  rd_only_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd |-> tx_active);
endmodule

bind smb_blkrd_ctrl smb_blkrd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_stop(ev_stop), .ev_addr(ev_addr), .addr_rw(addr_rw),
  .ev_rx(ev_rx), .rx_byte(rx_byte), .rx_ack(rx_ack), .tx_req(tx_req),
  .tx_valid(tx_valid), .ev_mack(ev_mack), .mack_ack(mack_ack), .tx_active(tx_active),
  .rf_rd(rf_rd), .base(base), .armed(armed), .in_cmd(in_cmd)
);

// File: tb/sim_smb_blkrd_ctrl.sv
`timescale 1ns/1ps
module sim_smb_blkrd_ctrl;
  logic clk = 0, rst_n = 0;
  logic ev_start = 0, ev_stop = 0, ev_addr = 0, addr_rw = 0, ev_rx = 0;
  logic [7:0] rx_byte = 0;
  logic tx_req = 0, ev_mack = 0, mack_ack = 0;
  logic rx_ack, tx_valid, tx_active, rf_rd;
  logic [7:0] tx_byte, rf_addr;
  logic [7:0] rf_data = 0;
  int n_chk = 0, n_bad = 0;
  int m_base = 0, m_len = 1;
  bit done = 0;

  always #2.5 clk = ~clk;

  smb_blkrd_ctrl u0 (.*);

  function automatic logic [7:0] reg_val(int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction
  function automatic logic [7:0] exp_data(int a);
    return (a > 255) ? 8'h00 : reg_val(a);
  endfunction

  always_ff @(posedge clk) if (rf_rd) rf_data <= reg_val(int'(rf_addr));

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask
  task automatic do_start(); pulse(ev_start); endtask
  task automatic do_stop(); pulse(ev_stop); endtask
  task automatic do_addr(bit rw);
    addr_rw = rw; pulse(ev_addr);
  endtask
  task automatic send(logic [7:0] b, bit exp, string req);
    rx_byte = b; ev_rx = 1; #1;
    chk(rx_ack === exp, req, rx_ack, exp);
    @(negedge clk); ev_rx = 0;
  endtask

  // setup write; nsend bytes (1..4) of cmd,cnt,adr,len then STOP
  task automatic setup(logic [7:0] cmd, logic [7:0] cnt, logic [7:0] adr, logic [7:0] ln,
                       int nsend, string req);
    logic [7:0] b[4];
    bit ok = 1;
    b[0] = cmd; b[1] = cnt; b[2] = adr; b[3] = ln;
    do_start(); do_addr(0);
    for (int i = 0; i < nsend; i++) begin
      bit v;
      case (i)
        0: v = (b[i] == 8'hF1);
        1: v = (b[i] == 8'h02);
        2: v = 1;
        default: v = (b[i] >= 8'h01) && (b[i] <= 8'h20);
      endcase
      ok = ok && v;
      send(b[i], ok, req);
    end
    do_stop();
    if (ok && nsend == 4) begin m_base = adr; m_len = ln; end
  endtask

  // armed block read; total = bytes sent incl. length byte, last one NACKed
  task automatic rd_block(int total, string req);
    do_start(); do_addr(0);
    send(8'hF1, 1, req);
    do_start(); do_addr(1);
    chk(tx_active === 1, "R6 tx_active", tx_active, 1);
    for (int k = 0; k < total; k++) begin
      logic [7:0] e;
      e = (k == 0) ? 8'(m_len) : exp_data(m_base);
      tx_req = 1; @(negedge clk); tx_req = 0;
      chk(tx_valid === 1 && tx_byte === e, (k == 0) ? "R6 len byte" : req, tx_byte, e);
      mack_ack = (k < total - 1);
      pulse(ev_mack);
      if (k > 0 && m_base < 256) m_base++;
    end
    chk(tx_active === 0, "R8 released", tx_active, 0);
    tx_req = 1; @(negedge clk); tx_req = 0;
    chk(tx_valid === 0, "R8 no tx after nack", tx_valid, 0);
    do_stop();
  endtask

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(tx_active === 0 && tx_valid === 0, "R1 reset outputs", tx_active, 0);
    rd_block(3, "R1 reset read");
    setup(8'hF1, 8'h02, 8'h10, 8'h04, 4, "R2 setup ack");
    rd_block(5, "R6 data");
    rd_block(5, "R9 resume");
    rd_block(9, "R7 past N");
    setup(8'hF1, 8'h03, 8'h40, 8'h04, 4, "R3 bad count");
    setup(8'hF1, 8'h02, 8'h40, 8'h00, 4, "R3 len 00");
    setup(8'hF1, 8'h02, 8'h40, 8'h21, 4, "R3 len 21");
    rd_block(2, "R3 unchanged");
    setup(8'hF5, 8'h02, 8'h40, 8'h04, 4, "R4 fixed cmd");
    setup(8'hF2, 8'h02, 8'h40, 8'h04, 2, "R4 fixed F2");
    setup(8'hFD, 8'h02, 8'h40, 8'h04, 1, "R4 fixed FD");
    setup(8'hF1, 8'h02, 8'h50, 8'h08, 3, "R5 mid stop");
    rd_block(2, "R5 discarded");
    setup(8'hF1, 8'h02, 8'h20, 8'h20, 4, "R2 len 20");
    rd_block(3, "R2 max len");
    // unarmed read
    do_start(); do_addr(1);
    chk(tx_active === 0, "R11 unarmed", tx_active, 0);
    do_stop();
    do_start(); do_addr(0); send(8'hF1, 1, "R11 arm"); do_stop();
    do_start(); do_addr(1);
    chk(tx_active === 0, "R11 stop disarms", tx_active, 0);
    do_stop();
    setup(8'hF1, 8'h02, 8'hFD, 8'h04, 4, "R10 setup");
    rd_block(7, "R10 top of space");
    rd_block(4, "R10 no wrap");
    for (int it = 0; it < 60; it++) begin
      logic [7:0] c, n, a, l;
      c = ($urandom % 6 == 0) ? 8'($urandom) : 8'hF1;
      n = ($urandom % 5 == 0) ? 8'($urandom % 4) : 8'h02;
      a = 8'($urandom);
      l = ($urandom % 6 == 0) ? 8'($urandom % 48) : 8'(1 + $urandom % 32);
      setup(c, n, a, l, 1 + int'($urandom % 4), "R2 random setup");
      rd_block(1 + int'($urandom % 40), "R6 random read");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule